// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which interrupt a 16550-style serial port presents to its host. Each cycle it looks at the interrupt enable bits, the receive line error flags, receive-data readiness, the receive FIFO fill level against its trigger level, a character-timeout flag, a transmit-holding-empty pending flag and the modem status change bits. From these it picks the single most urgent source, encodes it as an identification byte and drives one interrupt request line.

The transmit-empty pending flag lives inside the block. Host register strobes update it. Writing the enable register re-arms it while the holding register is empty. A transmit-holding-empty line that goes from busy to empty also sets it. Writing a data byte or reading the identification register clears it. The FIFO storage, the shifters, the baud logic and the address decoding sit outside. Only their status signals and single-cycle strobes reach this block.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte is 0x01, the enable register reads 0x0 and the interrupt line is low.
- R2: An enable write stores only data bits 3:0, readable on the enable output from the next cycle. The bits mean: bit 0 = received data, bit 1 = transmit empty, bit 2 = line status, bit 3 = modem status.
- R3: When several sources are active, the one reported is chosen in this order, highest first: line error (bit 2 enabled and any of overrun, parity, framing, break), character timeout, received data, transmit empty, modem change.
- R4: The low nibble of the identification byte is 0x6 for line error, 0xC for timeout, 0x4 for received data, 0x2 for transmit empty, 0x0 for modem change (bit 3 enabled and any of the four delta bits set), and 0x1 when nothing is pending.
- R5: With the FIFOs enabled, received data is reported only once the receive count is at least the trigger level. The trigger select values 0, 1, 2 and 3 give levels of 1, 4, 8 and 14 entries.
- R6: With the FIFOs disabled, received data is reported whenever the ready flag is set, whatever the count.
- R7: Bits 7:6 of the identification byte are 11 while the FIFOs are enabled and 00 otherwise. Bits 5:4 are always 0.
- R8: While the enable register is zero, the interrupt line stays low and the low nibble reads 0x1, even with sources active.
- R9: A read strobe on the identification register clears the transmit-empty pending flag.
- R10: An enable write made while the holding register is empty sets the transmit-empty pending flag.
- R11: A write to the transmit holding register clears the pending flag. A clear strobe on the same cycle as a set event wins.
- R12: The holding-empty input going from 0 to 1 sets the pending flag.
- R13: The interrupt line and the identification byte are registered. They follow input changes one cycle later, and the line is high exactly when the low nibble differs from 0x1.
- R14: The character timeout is reported whenever the enable register is non-zero, whichever enable bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| iir_rd | input | 1 | Identification register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| thr_empty | input | 1 | Transmit holding register is empty |
| fifo_en | input | 1 | FIFOs enabled |
| rx_trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CNT_W (5) | Receive FIFO fill count |
| rx_ready | input | 1 | Receive data ready |
| lsr_overrun | input | 1 | Overrun error flag |
| lsr_parity | input | 1 | Parity error flag |
| lsr_framing | input | 1 | Framing error flag |
| lsr_break | input | 1 | Break flag |
| char_timeout | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status change bits |
| ier_q | output | 4 | Enable register contents |
| iir_q | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Every cycle, the assertions check that the pending flag drops after a clear strobe and that enable writes keep only the low nibble. They also check that at most one source wins, that line errors pre-empt everything, that the FIFO-mode bits track the enable flag, and that a zero enable register forces the line low. Only the bench scenarios can show the full ordering, stepping down one source at a time. The same holds for each trigger level's exact threshold, the clear-wins collision on the pending flag, and the set path from a busy-to-empty transition.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int N_SRC = 5;

  // source index order is the priority order, index 0 highest
  localparam int SRC_LINE  = 0;
  localparam int SRC_TMO   = 1;
  localparam int SRC_RXD   = 2;
  localparam int SRC_TXE   = 3;
  localparam int SRC_MODEM = 4;

  localparam logic [3:0] ID_NONE  = 4'h1;
  localparam logic [3:0] ID_LINE  = 4'h6;
  localparam logic [3:0] ID_TMO   = 4'hC;
  localparam logic [3:0] ID_RXD   = 4'h4;
  localparam logic [3:0] ID_TXE   = 4'h2;
  localparam logic [3:0] ID_MODEM = 4'h0;

  // enable register bit positions
  localparam int EN_RXD   = 0;
  localparam int EN_TXE   = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  function automatic logic [3:0] src_id(input int idx);
    case (idx)
      SRC_LINE:  return ID_LINE;
      SRC_TMO:   return ID_TMO;
      SRC_RXD:   return ID_RXD;
      SRC_TXE:   return ID_TXE;
      default:   return ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int EN_W = 4,
  parameter int WD_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ier_wr,
  input  logic [WD_W-1:0] ier_wdata,
  input  logic            iir_rd,
  input  logic            thr_wr,
  input  logic            thr_empty,
  output logic [EN_W-1:0] ier_q,
  output logic            txe_pend
);
  logic empty_d;
  logic set_ev;
  logic clr_ev;

  // busy-to-empty edge or enable write while empty re-arms the flag
  assign set_ev = (ier_wr && thr_empty) || (thr_empty && !empty_d);
  assign clr_ev = iir_rd || thr_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q    <= '0;
      txe_pend <= 1'b0;
      empty_d  <= 1'b1;
    end else begin
      empty_d <= thr_empty;
      if (ier_wr) ier_q <= ier_wdata[EN_W-1:0];
      if (clr_ev)      txe_pend <= 1'b0;
      else if (set_ev) txe_pend <= 1'b1;
    end
  end

  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr_ev |=> !txe_pend);

  assert_ier_low_nibble_R2: assert property (@(posedge clk) disable iff (rst)
    ier_wr |=> ier_q == $past(ier_wdata[EN_W-1:0]));

  assert_pend_set_R10: assert property (@(posedge clk) disable iff (rst)
    (ier_wr && thr_empty && !clr_ev) |=> txe_pend);
endmodule

// File: rtl/rx_trig_gate.sv
module rx_trig_gate #(
  parameter int CNT_W  = 5,
  parameter int TRIG_0 = 1,
  parameter int TRIG_1 = 4,
  parameter int TRIG_2 = 8,
  parameter int TRIG_3 = 14
) (
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] count,
  input  logic             ready,
  output logic             rx_req
);
  logic [CNT_W-1:0] level;

  always_comb begin
    case (trig_sel)
      2'd0:    level = CNT_W'(TRIG_0);
      2'd1:    level = CNT_W'(TRIG_1);
      2'd2:    level = CNT_W'(TRIG_2);
      default: level = CNT_W'(TRIG_3);
    endcase
  end

  always_comb begin
    if (!ready)        rx_req = 1'b0;
    else if (!fifo_en) rx_req = 1'b1;
    else               rx_req = (count >= level);
  end

  always_comb begin
    if (fifo_en && ready && (count < CNT_W'(TRIG_0)))
      assert_below_min_level_R5: assert (!rx_req);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int N = N_SRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic [3:0]   id
);
  logic [N-1:0] blocked;

  // blocked[i]: some higher-priority source is requesting
  assign blocked[0] = 1'b0;
  generate
    for (genvar i = 1; i < N; i++) begin : g_chain
      assign blocked[i] = blocked[i-1] | req[i-1];
    end
    for (genvar i = 0; i < N; i++) begin : g_grant
      assign grant[i] = req[i] & ~blocked[i];
    end
  endgenerate

  always_comb begin
    id = ID_NONE;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) id = src_id(i);
    end
  end

  assert_single_grant_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_grant_when_req_R3: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> (|grant));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int EN_W       = 4,
  parameter int WD_W       = 8,
  parameter int TRIG_0     = 1,
  parameter int TRIG_1     = 4,
  parameter int TRIG_2     = 8,
  parameter int TRIG_3     = 14,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ier_wr,
  input  logic [WD_W-1:0]  ier_wdata,
  input  logic             iir_rd,
  input  logic             thr_wr,
  input  logic             thr_empty,
  input  logic             fifo_en,
  input  logic [1:0]       rx_trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_ready,
  input  logic             lsr_overrun,
  input  logic             lsr_parity,
  input  logic             lsr_framing,
  input  logic             lsr_break,
  input  logic             char_timeout,
  input  logic [3:0]       msr_delta,
  output logic [EN_W-1:0]  ier_q,
  output logic [7:0]       iir_q,
  output logic             irq
);
  logic             txe_pend;
  logic             rx_req;
  logic             line_err;
  logic [N_SRC-1:0] req;
  logic [N_SRC-1:0] grant;
  logic [3:0]       id_sel;
  logic [3:0]       id_next;

  irq_enable_reg #(.EN_W(EN_W), .WD_W(WD_W)) u_en (
    .clk       (clk),
    .rst       (rst),
    .ier_wr    (ier_wr),
    .ier_wdata (ier_wdata),
    .iir_rd    (iir_rd),
    .thr_wr    (thr_wr),
    .thr_empty (thr_empty),
    .ier_q     (ier_q),
    .txe_pend  (txe_pend)
  );

  rx_trig_gate #(
    .CNT_W(CNT_W), .TRIG_0(TRIG_0), .TRIG_1(TRIG_1),
    .TRIG_2(TRIG_2), .TRIG_3(TRIG_3)
  ) u_rx (
    .fifo_en  (fifo_en),
    .trig_sel (rx_trig_sel),
    .count    (rx_count),
    .ready    (rx_ready),
    .rx_req   (rx_req)
  );

  assign line_err = lsr_overrun | lsr_parity | lsr_framing | lsr_break;

  always_comb begin
    req            = '0;
    req[SRC_LINE]  = ier_q[EN_LINE] & line_err;
    req[SRC_TMO]   = char_timeout;
    req[SRC_RXD]   = ier_q[EN_RXD] & rx_req;
    req[SRC_TXE]   = ier_q[EN_TXE] & txe_pend;
    req[SRC_MODEM] = ier_q[EN_MODEM] & (|msr_delta);
  end

  irq_prio_enc #(.N(N_SRC)) u_prio (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .grant (grant),
    .id    (id_sel)
  );

  // an all-zero enable register masks every source, timeout included
  assign id_next = (ier_q == '0) ? ID_NONE : id_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_q <= {4'h0, ID_NONE};
      irq   <= 1'b0;
    end else begin
      iir_q <= {{2{fifo_en}}, 2'b00, id_next};
      irq   <= (id_next != ID_NONE);
    end
  end

  assert_masked_line_low_R8: assert property (@(posedge clk) disable iff (rst)
    (ier_q == '0) |=> !irq);

  assert_irq_matches_id_R13: assert property (@(posedge clk) disable iff (rst)
    irq == (iir_q[3:0] != ID_NONE));

  assert_fifo_bits_on_R7: assert property (@(posedge clk) disable iff (rst)
    fifo_en |=> iir_q[7:4] == 4'b1100);

  assert_fifo_bits_off_R7: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> iir_q[7:4] == 4'b0000);

  assert_line_first_R3: assert property (@(posedge clk) disable iff (rst)
    (ier_q[EN_LINE] && line_err) |=> iir_q[3:0] == ID_LINE);
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       ier_wr, iir_rd, thr_wr, thr_empty, fifo_en;
  logic [7:0] ier_wdata;
  logic [1:0] rx_trig_sel;
  logic [4:0] rx_count;
  logic       rx_ready, lsr_overrun, lsr_parity, lsr_framing, lsr_break;
  logic       char_timeout;
  logic [3:0] msr_delta;
  logic [3:0] ier_q;
  logic [7:0] iir_q;
  logic       irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ident u_dut (
    .clk(clk), .rst(rst), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .iir_rd(iir_rd), .thr_wr(thr_wr), .thr_empty(thr_empty),
    .fifo_en(fifo_en), .rx_trig_sel(rx_trig_sel), .rx_count(rx_count),
    .rx_ready(rx_ready), .lsr_overrun(lsr_overrun), .lsr_parity(lsr_parity),
    .lsr_framing(lsr_framing), .lsr_break(lsr_break),
    .char_timeout(char_timeout), .msr_delta(msr_delta),
    .ier_q(ier_q), .iir_q(iir_q), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // expected identification byte and line together
  task automatic check_id(input string tag, input logic [7:0] exp);
    check({tag, " iir"}, iir_q, exp);
    check({tag, " irq"}, irq, (exp[3:0] != 4'h1));
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; ier_wr = 0; ier_wdata = 0; iir_rd = 0; thr_wr = 0;
    thr_empty = 0; fifo_en = 0; rx_trig_sel = 0; rx_count = 0;
    rx_ready = 0; lsr_overrun = 0; lsr_parity = 0; lsr_framing = 0;
    lsr_break = 0; char_timeout = 0; msr_delta = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    settle();
  endtask

  task automatic write_ier(input logic [7:0] d);
    ier_wdata = d; ier_wr = 1'b1;
    @(negedge clk);
    ier_wr = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    apply_reset();
    check("R1 ier", ier_q, 0);
    check_id("R1", 8'h01);
  endtask

  task automatic t_ier_write();
    apply_reset();
    write_ier(8'hFF);
    check("R2 ier keeps low nibble", ier_q, 4'hF);
    check_id("R2 nothing pending", 8'h01);
    write_ier(8'hA5);
    check("R2 ier second write", ier_q, 4'h5);
  endtask

  task automatic t_priority();
    apply_reset();
    write_ier(8'h0F);
    msr_delta = 4'b0100; settle();
    check_id("R4 modem", 8'h00);
    thr_empty = 1'b1; settle();
    check_id("R12 R3 tx empty over modem", 8'h02);
    rx_ready = 1'b1; settle();
    check_id("R3 rx over tx", 8'h04);
    char_timeout = 1'b1; settle();
    check_id("R3 timeout over rx", 8'h0C);
    lsr_framing = 1'b1; settle();
    check_id("R3 line over timeout", 8'h06);
    lsr_framing = 1'b0; lsr_break = 1'b1; settle();
    check_id("R4 break is line error", 8'h06);
    lsr_break = 1'b0; char_timeout = 1'b0; settle();
    check_id("R3 back to rx", 8'h04);
    rx_ready = 1'b0; settle();
    check_id("R3 back to tx", 8'h02);
    iir_rd = 1'b1; @(negedge clk); iir_rd = 1'b0; settle();
    check_id("R9 back to modem", 8'h00);
    msr_delta = 4'b0; settle();
    check_id("R4 none", 8'h01);
  endtask

  task automatic t_latency();
    apply_reset();
    write_ier(8'h04);
    lsr_overrun = 1'b1;
    @(posedge clk); #1;
    check("R13 irq one cycle after input", irq, 1);
    check("R13 id one cycle after input", iir_q, 8'h06);
  endtask

  task automatic t_fifo_gate();
    int lv[4] = '{1, 4, 8, 14};
    apply_reset();
    write_ier(8'h01);
    fifo_en = 1'b1; rx_ready = 1'b1;
    for (int s = 0; s < 4; s++) begin
      rx_trig_sel = 2'(s);
      rx_count = 5'(lv[s] - 1); settle();
      check_id($sformatf("R5 R7 below level %0d", lv[s]), 8'hC1);
      rx_count = 5'(lv[s]); settle();
      check_id($sformatf("R5 R7 at level %0d", lv[s]), 8'hC4);
    end
    rx_count = 5'd16; settle();
    check_id("R5 full", 8'hC4);
  endtask

  task automatic t_fifo_off();
    apply_reset();
    write_ier(8'h01);
    rx_trig_sel = 2'd3; rx_count = 0; rx_ready = 1'b1; settle();
    check_id("R6 R7 no fifo any data", 8'h04);
  endtask

  task automatic t_masked();
    apply_reset();
    lsr_parity = 1'b1; char_timeout = 1'b1; rx_ready = 1'b1;
    msr_delta = 4'hF; thr_empty = 1'b1; settle();
    check_id("R8 zero enable", 8'h01);
    lsr_parity = 1'b0; rx_ready = 1'b0;
    write_ier(8'h08);
    check_id("R14 timeout with modem enable only", 8'h0C);
  endtask

  task automatic t_txe_flag();
    apply_reset();
    thr_empty = 1'b1; settle();
    write_ier(8'h02);
    check_id("R10 enable write while empty", 8'h02);
    iir_rd = 1'b1; @(negedge clk); iir_rd = 1'b0; settle();
    check_id("R9 read clears", 8'h01);
    write_ier(8'h02);
    check_id("R10 re-armed", 8'h02);
    thr_wr = 1'b1; @(negedge clk); thr_wr = 1'b0; settle();
    check_id("R11 data write clears", 8'h01);
    ier_wdata = 8'h02; ier_wr = 1'b1; thr_wr = 1'b1;
    @(negedge clk);
    ier_wr = 1'b0; thr_wr = 1'b0; settle();
    check_id("R11 clear wins", 8'h01);
    thr_empty = 1'b0; settle();
    check_id("R12 busy no irq", 8'h01);
    thr_empty = 1'b1; settle();
    check_id("R12 empty edge sets", 8'h02);
  endtask

  initial begin
    rst = 1'b1;
    t_reset();
    t_ier_write();
    t_priority();
    t_latency();
    t_fifo_gate();
    t_fifo_off();
    t_masked();
    t_txe_flag();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule